// File: doc/BRIEF.md
# Sub-word Aliased General Register File

This block holds the working registers of a small integer datapath: four data registers, two index registers and two pointer registers, each 32 bits wide. Software-visible operand sizes are narrower than the storage. Every register can be reached as a full word or as its lower half-word. The four data registers can also be reached as two separate bytes, the upper and lower byte of the lower half-word.

One write port and two read ports share the same addressing: a register select, a size code and a byte-half select. A narrow write merges into the stored word and leaves every other bit alone. A narrow read returns the chosen slice, shifted down to bit 0 and zero-extended. An access that asks for a byte of a register with no byte aliases, or that uses the reserved size code, raises an illegal flag on that port and has no effect on the stored state.

Top module: `gpr_alias_file`

## Requirements
- R1: Register select values 0 to 3 name the data registers, 4 and 5 the index registers, and 6 and 7 the pointer registers. A word write (size code 2'b10) replaces all 32 bits of the selected register only, and a later word read of that register returns the written value.
- R2: A half-word write (size code 2'b01) replaces bits 15:0 of the selected register and keeps bits 31:16.
- R3: A byte write (size code 2'b00) to a data register replaces bits 15:8 when the half select is 1, and bits 7:0 when it is 0. All other bits, including the other byte of the same half-word, are kept.
- R4: Byte-size accesses to selects 4 to 7, and any access with size code 2'b11, raise the illegal flag of that port. An illegal write changes no register, and an illegal read returns zero.
- R5: A read returns the selected slice zero-extended to 32 bits. For the upper byte alias, this means bits 15:8 of the register are returned in bits 7:0.
- R6: Reads are combinational. A read of the register being written returns the old value during the write cycle and the new value after the clock edge.
- R7: While rst_n is low, every register reads as zero. The reset takes effect without waiting for a clock edge.
- R8: The two read ports decode their own select, size and half inputs independently of each other and of the write port.
- R9: With wr_en low, no register changes and wr_illegal stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_sel | input | 3 | Write register select |
| wr_size | input | 2 | Write size code: 00 byte, 01 half-word, 10 word, 11 reserved |
| wr_hi | input | 1 | Byte write half select: 1 upper byte, 0 lower byte |
| wr_data | input | 32 | Write data, right-aligned |
| wr_illegal | output | 1 | Write request was illegal and was dropped |
| rd_a_sel | input | 3 | Read port A register select |
| rd_a_size | input | 2 | Read port A size code |
| rd_a_hi | input | 1 | Read port A byte half select |
| rd_a_data | output | 32 | Read port A zero-extended slice |
| rd_a_illegal | output | 1 | Read port A access is illegal |
| rd_b_sel | input | 3 | Read port B register select |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_hi | input | 1 | Read port B byte half select |
| rd_b_data | output | 32 | Read port B zero-extended slice |
| rd_b_illegal | output | 1 | Read port B access is illegal |

## Verification
The bench builds the block with its default configuration: four data, two index and two pointer registers, each 32 bits. At that size, every combination of select, size code and half select can be swept on the write port. After each write, every combination can be swept again on both read ports. Legal byte aliases, the illegal byte-on-index and byte-on-pointer cases, and the reserved size code are all visited against a bench model. Same-cycle read-during-write, a held-off write and a mid-run reset are covered by directed steps.

// File: rtl/gpr_alias_pkg.sv
package gpr_alias_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/gpr_access_decode.sv
module gpr_access_decode
  import gpr_alias_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned NUM_DATA = 4,
  parameter int unsigned LANES    = 4,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS),
  localparam int unsigned SHIFT_W = $clog2(LANES)
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [1:0]         size,
  input  logic               hi,
  output logic [LANES-1:0]   lane_en,
  output logic [LANES-1:0]   keep,
  output logic [SHIFT_W-1:0] shift,
  output logic               illegal
);
  localparam int unsigned HALF_LANES = LANES / 2;
  localparam logic [LANES-1:0] HALF_KEEP =
    {{(LANES-HALF_LANES){1'b0}}, {HALF_LANES{1'b1}}};
  localparam logic [LANES-1:0] BYTE_KEEP = LANES'(1);
  localparam logic [SEL_W:0]   DATA_LIM  = (SEL_W+1)'(NUM_DATA);

  logic has_bytes;

  always_comb begin
    has_bytes = ({1'b0, sel} < DATA_LIM);
    keep      = '0;
    shift     = '0;
    illegal   = 1'b0;
    case (acc_size_e'(size))
      SZ_BYTE: begin
        if (has_bytes) begin
          keep  = BYTE_KEEP;
          shift = hi ? SHIFT_W'(1) : '0;
        end else begin
          illegal = 1'b1;
        end
      end
      SZ_HALF: keep = HALF_KEEP;
      SZ_WORD: keep = '1;
      default: illegal = 1'b1;
    endcase
    lane_en = keep << shift;
  end
endmodule

// File: rtl/gpr_read_slice.sv
module gpr_read_slice
  import gpr_alias_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned LANES   = DATA_W / LANE_W,
  localparam int unsigned SHIFT_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0]  word,
  input  logic [LANES-1:0]   keep,
  input  logic [SHIFT_W-1:0] shift,
  output logic [DATA_W-1:0]  data
);
  logic [DATA_W-1:0] shifted;

  always_comb shifted = word >> (32'(shift) * LANE_W);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb data[l*LANE_W +: LANE_W] = keep[l] ? shifted[l*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
  import gpr_alias_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned LANES   = DATA_W / LANE_W,
  localparam int unsigned SHIFT_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0]  old_word,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [LANES-1:0]   lane_en,
  input  logic [SHIFT_W-1:0] shift,
  output logic [DATA_W-1:0]  merged
);
  logic [DATA_W-1:0] aligned;

  always_comb aligned = wdata << (32'(shift) * LANE_W);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb merged[l*LANE_W +: LANE_W] =
      lane_en[l] ? aligned[l*LANE_W +: LANE_W] : old_word[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file
  import gpr_alias_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_DATA = 4,
  parameter int unsigned NUM_IDX  = 2,
  parameter int unsigned NUM_PTR  = 2,
  localparam int unsigned NUM_REGS = NUM_DATA + NUM_IDX + NUM_PTR,
  localparam int unsigned SEL_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [1:0]        wr_size,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_illegal,
  input  logic [SEL_W-1:0]  rd_a_sel,
  input  logic [1:0]        rd_a_size,
  input  logic              rd_a_hi,
  output logic [DATA_W-1:0] rd_a_data,
  output logic              rd_a_illegal,
  input  logic [SEL_W-1:0]  rd_b_sel,
  input  logic [1:0]        rd_b_size,
  input  logic              rd_b_hi,
  output logic [DATA_W-1:0] rd_b_data,
  output logic              rd_b_illegal
);
  localparam int unsigned LANES   = DATA_W / LANE_W;
  localparam int unsigned SHIFT_W = $clog2(LANES);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_d;
  logic [NUM_REGS-1:0]             reg_we;

  // write path decode and merge
  logic [LANES-1:0]   w_lane_en, w_keep;
  logic [SHIFT_W-1:0] w_shift;
  logic               w_bad, wr_go;
  logic [DATA_W-1:0]  w_merged;

  gpr_access_decode #(.NUM_REGS(NUM_REGS), .NUM_DATA(NUM_DATA), .LANES(LANES)) u_wdec (
    .sel(wr_sel), .size(wr_size), .hi(wr_hi),
    .lane_en(w_lane_en), .keep(w_keep), .shift(w_shift), .illegal(w_bad)
  );

  gpr_write_merge #(.DATA_W(DATA_W)) u_merge (
    .old_word(regs_q[wr_sel]), .wdata(wr_data),
    .lane_en(w_lane_en), .shift(w_shift), .merged(w_merged)
  );

  always_comb begin
    wr_go      = wr_en & ~w_bad;
    wr_illegal = wr_en & w_bad;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_next
    always_comb begin
      reg_we[r] = wr_go && (wr_sel == SEL_W'(r));
      regs_d[r] = reg_we[r] ? w_merged : regs_q[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (reg_we[r]) regs_q[r] <= regs_d[r];
      end
    end
  end

  // read ports
  logic [LANES-1:0]   a_lane_en, a_keep, b_lane_en, b_keep;
  logic [SHIFT_W-1:0] a_shift, b_shift;

  gpr_access_decode #(.NUM_REGS(NUM_REGS), .NUM_DATA(NUM_DATA), .LANES(LANES)) u_adec (
    .sel(rd_a_sel), .size(rd_a_size), .hi(rd_a_hi),
    .lane_en(a_lane_en), .keep(a_keep), .shift(a_shift), .illegal(rd_a_illegal)
  );

  gpr_read_slice #(.DATA_W(DATA_W)) u_aslice (
    .word(regs_q[rd_a_sel]), .keep(a_keep), .shift(a_shift), .data(rd_a_data)
  );

  gpr_access_decode #(.NUM_REGS(NUM_REGS), .NUM_DATA(NUM_DATA), .LANES(LANES)) u_bdec (
    .sel(rd_b_sel), .size(rd_b_size), .hi(rd_b_hi),
    .lane_en(b_lane_en), .keep(b_keep), .shift(b_shift), .illegal(rd_b_illegal)
  );

  gpr_read_slice #(.DATA_W(DATA_W)) u_bslice (
    .word(regs_q[rd_b_sel]), .keep(b_keep), .shift(b_shift), .data(rd_b_data)
  );

  logic unused_lanes;
  always_comb unused_lanes = ^{a_lane_en, b_lane_en, w_keep};
endmodule

// File: rtl/gpr_alias_file_chk.sv
module gpr_alias_file_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_DATA = 4,
  parameter int unsigned NUM_REGS = 8,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            wr_en,
  input logic [SEL_W-1:0]                wr_sel,
  input logic [1:0]                      wr_size,
  input logic                            wr_hi,
  input logic [DATA_W-1:0]               wr_data,
  input logic                            wr_illegal,
  input logic [1:0]                      rd_a_size,
  input logic [DATA_W-1:0]               rd_a_data,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);
  localparam logic [SEL_W:0] DATA_LIM = (SEL_W+1)'(NUM_DATA);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r7: assert (regs_q == '0);
    end
  end

  p_word_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'b10) |=> (regs_q[$past(wr_sel)] == $past(wr_data)));

  p_half_keeps_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'b01) |=>
      (regs_q[$past(wr_sel)][DATA_W-1:16] == $past(regs_q[wr_sel][DATA_W-1:16])) &&
      (regs_q[$past(wr_sel)][15:0] == $past(wr_data[15:0])));

  p_byte_hi_keeps_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_illegal && wr_size == 2'b00 && wr_hi) |=>
      (regs_q[$past(wr_sel)][7:0] == $past(regs_q[wr_sel][7:0])) &&
      (regs_q[$past(wr_sel)][DATA_W-1:16] == $past(regs_q[wr_sel][DATA_W-1:16])) &&
      (regs_q[$past(wr_sel)][15:8] == $past(wr_data[7:0])));

  p_byte_lo_keeps_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_illegal && wr_size == 2'b00 && !wr_hi) |=>
      (regs_q[$past(wr_sel)][DATA_W-1:8] == $past(regs_q[wr_sel][DATA_W-1:8])) &&
      (regs_q[$past(wr_sel)][7:0] == $past(wr_data[7:0])));

  p_byte_on_wide_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_size == 2'b00 && ({1'b0, wr_sel} >= DATA_LIM)) |-> wr_illegal);

  p_illegal_no_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_illegal |=> $stable(regs_q));

  p_read_zero_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_size == 2'b00) |-> (rd_a_data[DATA_W-1:8] == '0));

  p_idle_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));
endmodule

bind gpr_alias_file gpr_alias_file_chk #(
  .DATA_W(DATA_W), .NUM_DATA(NUM_DATA), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size),
  .wr_hi(wr_hi), .wr_data(wr_data), .wr_illegal(wr_illegal),
  .rd_a_size(rd_a_size), .rd_a_data(rd_a_data), .regs_q(regs_q)
);

// File: tb/gpr_alias_file_tb_top.sv
module gpr_alias_file_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [1:0]  wr_size;
  logic        wr_hi;
  logic [31:0] wr_data;
  logic        wr_illegal;
  logic [2:0]  rd_a_sel, rd_b_sel;
  logic [1:0]  rd_a_size, rd_b_size;
  logic        rd_a_hi, rd_b_hi;
  logic [31:0] rd_a_data, rd_b_data;
  logic        rd_a_illegal, rd_b_illegal;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          done = 1'b0;
  logic [31:0] mdl [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpr_alias_file dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_size(wr_size),
    .wr_hi(wr_hi), .wr_data(wr_data), .wr_illegal(wr_illegal),
    .rd_a_sel(rd_a_sel), .rd_a_size(rd_a_size), .rd_a_hi(rd_a_hi),
    .rd_a_data(rd_a_data), .rd_a_illegal(rd_a_illegal),
    .rd_b_sel(rd_b_sel), .rd_b_size(rd_b_size), .rd_b_hi(rd_b_hi),
    .rd_b_data(rd_b_data), .rd_b_illegal(rd_b_illegal)
  );

  function automatic bit legal(int sel, int sz);
    if (sz == 3) return 1'b0;
    if (sz == 0 && sel >= 4) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] exp_read(logic [31:0] v, int sel, int sz, bit hi);
    if (!legal(sel, sz)) return 32'h0;
    case (sz)
      0:       return hi ? ((v >> 8) & 32'hFF) : (v & 32'hFF);
      1:       return v & 32'hFFFF;
      default: return v;
    endcase
  endfunction

  function automatic logic [31:0] exp_write(logic [31:0] v, int sz, bit hi, logic [31:0] d);
    case (sz)
      0:       return hi ? {v[31:16], d[7:0], v[7:0]} : {v[31:8], d[7:0]};
      1:       return {v[31:16], d[15:0]};
      default: return d;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // sweep every read combination on both ports against the model
  task automatic sweep_reads(string req);
    for (int r = 0; r < 8; r++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int h = 0; h < 2; h++) begin
          rd_a_sel = 3'(r); rd_a_size = 2'(sz); rd_a_hi = h[0];
          rd_b_sel = 3'(7 - r); rd_b_size = 2'(3 - sz); rd_b_hi = ~h[0];
          #1;
          check({req, " R5 port A data"}, rd_a_data, exp_read(mdl[r], r, sz, h[0]));
          check("R4 port A illegal flag", {31'b0, rd_a_illegal}, {31'b0, ~legal(r, sz)});
          check("R8 port B data", rd_b_data, exp_read(mdl[7-r], 7 - r, 3 - sz, ~h[0]));
        end
      end
    end
  endtask

  task automatic do_write(int sel, int sz, bit hi, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_size = 2'(sz); wr_hi = hi; wr_data = d;
    rd_a_sel = 3'(sel); rd_a_size = 2'b10; rd_a_hi = 1'b0;
    #1;
    check("R6 old value during write", rd_a_data, mdl[sel]);
    check("R4 write illegal flag", {31'b0, wr_illegal}, {31'b0, ~legal(sel, sz)});
    @(posedge clk);
    #1;
    if (legal(sel, sz)) mdl[sel] = exp_write(mdl[sel], sz, hi, d);
    wr_en = 1'b0;
    check("R6 new value after edge", rd_a_data, mdl[sel]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_size = '0; wr_hi = 1'b0; wr_data = '0;
    rd_a_sel = '0; rd_a_size = '0; rd_a_hi = 1'b0;
    rd_b_sel = '0; rd_b_size = '0; rd_b_hi = 1'b0;
    for (int r = 0; r < 8; r++) mdl[r] = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    sweep_reads("R7 reset state");
    rst_n = 1'b1;

    // word writes to every register first
    for (int r = 0; r < 8; r++) begin
      do_write(r, 2, 1'b0, 32'hC3A50000 ^ (32'(r) * 32'h11111111));
      sweep_reads("R1 word write");
    end

    // every select, size code and half select
    for (int r = 0; r < 8; r++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int h = 0; h < 2; h++) begin
          logic [31:0] pat;
          pat = 32'h9E3779B9 * 32'(r * 8 + sz * 2 + h + 1);
          do_write(r, sz, h[0], pat);
          sweep_reads("R2 R3 R4 narrow write");
        end
      end
    end

    // write request held off: no change and no illegal flag
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 3'd5; wr_size = 2'b00; wr_hi = 1'b1; wr_data = 32'hFFFFFFFF;
    #1;
    check("R9 no flag when idle", {31'b0, wr_illegal}, 32'h0);
    @(posedge clk);
    #1;
    wr_sel = 3'd2; wr_size = 2'b10;
    @(posedge clk);
    #1;
    sweep_reads("R9 idle write");

    // asynchronous mid-run reset
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    for (int r = 0; r < 8; r++) mdl[r] = '0;
    sweep_reads("R7 async reset");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule